// File: doc/BRIEF.md
# Paged Address Translator with Translation Buffer

This block turns logical addresses issued by a processor into physical addresses using 4096-byte pages. The low 12 bits of an address are the byte offset inside a page and pass through untouched. The bits above them are the page number, which is translated to a frame number. A small fully associative translation buffer is checked first, comparing the page number against every stored key at once. On a hit, the answer comes back one cycle after the request is accepted and no memory traffic occurs.

On a miss, the block reads one 32-bit page-table entry through a ready/valid read port. The entry sits at the page-table base register plus four times the page number. The block stores the entry in the buffer, using round-robin replacement, and then answers the request. Each entry carries its frame number and valid, read, write and execute permission bits. The block checks every access against these bits. It returns either a physical address or a fault code. An entry that faults is still kept, so a repeated faulting access is answered without another table read. A flush input empties the buffer in one cycle.

Top module: `page_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0, and the buffer is empty, so the first access to any page reads the table.
- R2: Page-table entry layout: bit 0 valid, bit 1 read, bit 2 write, bit 3 execute, and bits 31:12 the frame number. A response without a fault returns `{frame, vaddr[11:0]}`.
- R3: On a miss, exactly one table read is issued, at `pt_base + 4*page`. `mem_req_valid` and `mem_req_addr` hold steady until `mem_req_ready`. The response follows in the cycle after `mem_rsp_valid`.
- R4: On a hit, `rsp_valid` rises in the cycle after the request is accepted, and no table read is issued.
- R5: After a miss has been filled, a later access to the same page hits, whatever its offset.
- R6: Access to an entry with its valid bit clear gives fault code 1, whatever the access type. The entry is still installed, so a repeated access gives fault 1 again without a table read.
- R7: Access type codes are 0 for read, 1 for write and 2 for execute. A write without the write bit gives fault 2. An execute without the execute bit gives fault 3. A read without the read bit gives fault 1. An invalid page reports 1 ahead of any permission fault.
- R8: Whenever `rsp_fault` is nonzero, `rsp_paddr` is 0.
- R9: The buffer holds 8 entries and is filled in round-robin order. The ninth distinct page filled evicts the first of those nine, and the others still hit.
- R10: A cycle with `flush` high clears every buffer entry, so the next access to any page misses.
- R11: If `flush` is high in the same cycle as `mem_rsp_valid`, the response is still delivered correctly, but the entry is not kept.
- R12: `pt_base` is loaded from `pt_base_d` in any cycle where `pt_base_we` is high, and later table reads use the new base.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all buffer entries |
| pt_base_we | input | 1 | Load page-table base register |
| pt_base_d | input | PA_W | New page-table base |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Block can accept a request |
| req_vaddr | input | VA_W | Logical address |
| req_acc | input | 2 | Access type: 0 read, 1 write, 2 execute |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | PA_W | Physical address, 0 on fault |
| rsp_fault | output | 2 | 0 none, 1 invalid or unreadable, 2 write, 3 execute |
| mem_req_valid | output | 1 | Page-table read request |
| mem_req_addr | output | PA_W | Page-table entry address |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_rsp_valid | input | 1 | Read data present |
| mem_rsp_data | input | PA_W | Page-table entry |

## Verification
Flush and the fill of a missed entry can land in the same cycle. The bench provokes this by having its memory model raise `flush` on the exact cycle it returns the table entry. It then judges two things: the pending response must still carry the right frame and no fault, and a second access to the same page must issue a new table read. The memory model also withholds `mem_req_ready` for a few cycles, to show that the table read holds steady while it waits.

// File: rtl/page_xlate.sv
module page_xlate #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12,
  parameter int TLB_N = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            flush,
  input  logic            pt_base_we,
  input  logic [PA_W-1:0] pt_base_d,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [VA_W-1:0] req_vaddr,
  input  logic [1:0]      req_acc,
  output logic            rsp_valid,
  output logic [PA_W-1:0] rsp_paddr,
  output logic [1:0]      rsp_fault,
  output logic            mem_req_valid,
  output logic [PA_W-1:0] mem_req_addr,
  input  logic            mem_req_ready,
  input  logic            mem_rsp_valid,
  input  logic [PA_W-1:0] mem_rsp_data
);
  localparam int VPN_W = VA_W - OFF_W;
  localparam int PFN_W = PA_W - OFF_W;
  localparam int IDX_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_WAIT} state_t;
  state_t state;

  logic [TLB_N-1:0] tv;
  logic [VPN_W-1:0] tkey  [TLB_N];
  logic [PFN_W-1:0] tpfn  [TLB_N];
  logic [3:0]       tperm [TLB_N];
  logic [IDX_W-1:0] rr;

  logic [PA_W-1:0]  pt_base;
  logic [VPN_W-1:0] cur_vpn;
  logic [OFF_W-1:0] cur_off;
  logic [1:0]       cur_acc;

  logic [VPN_W-1:0] req_vpn;
  logic [TLB_N-1:0] hitv;
  logic [PFN_W-1:0] hpfn;
  logic [3:0]       hperm;
  logic [1:0]       hit_fault, fill_fault;
  logic             fill_en;

  function automatic logic [1:0] perm_chk(input logic [3:0] p, input logic [1:0] acc);
    if (!p[0])         return 2'd1;
    else if (acc == 2'd1) return p[2] ? 2'd0 : 2'd2;
    else if (acc == 2'd2) return p[3] ? 2'd0 : 2'd3;
    else               return p[1] ? 2'd0 : 2'd1;
  endfunction

  assign req_vpn       = req_vaddr[VA_W-1:OFF_W];
  assign req_ready     = (state == S_IDLE);
  assign mem_req_valid = (state == S_REQ);
  assign mem_req_addr  = pt_base + PA_W'({cur_vpn, 2'b00});
  assign fill_en       = (state == S_WAIT) && mem_rsp_valid && !flush;

  genvar i;
  generate
    for (i = 0; i < TLB_N; i++) begin : g_cmp
      assign hitv[i] = tv[i] && (tkey[i] == req_vpn);
    end
  endgenerate

  always_comb begin
    hpfn  = '0;
    hperm = '0;
    for (int k = 0; k < TLB_N; k++) begin
      if (hitv[k]) begin
        hpfn  = hpfn | tpfn[k];
        hperm = hperm | tperm[k];
      end
    end
  end

  assign hit_fault  = perm_chk(hperm, req_acc);
  assign fill_fault = perm_chk(mem_rsp_data[3:0], cur_acc);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      tv        <= '0;
      rr        <= '0;
      pt_base   <= '0;
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= '0;
      cur_vpn   <= '0;
      cur_off   <= '0;
      cur_acc   <= '0;
    end else begin
      rsp_valid <= 1'b0;
      if (pt_base_we) pt_base <= pt_base_d;
      case (state)
        S_IDLE: if (req_valid) begin
          if (|hitv) begin
            rsp_valid <= 1'b1;
            rsp_fault <= hit_fault;
            rsp_paddr <= (hit_fault == 2'd0) ? {hpfn, req_vaddr[OFF_W-1:0]} : '0;
          end else begin
            cur_vpn <= req_vpn;
            cur_off <= req_vaddr[OFF_W-1:0];
            cur_acc <= req_acc;
            state   <= S_REQ;
          end
        end
        S_REQ: if (mem_req_ready) state <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          rsp_valid <= 1'b1;
          rsp_fault <= fill_fault;
          rsp_paddr <= (fill_fault == 2'd0) ? {mem_rsp_data[PA_W-1:OFF_W], cur_off} : '0;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
      if (fill_en) begin
        tv[rr] <= 1'b1;
        rr     <= (rr == IDX_W'(TLB_N - 1)) ? '0 : rr + 1'b1;
      end
      if (flush) tv <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_en) begin
      tkey[rr]  <= cur_vpn;
      tpfn[rr]  <= mem_rsp_data[PA_W-1:OFF_W];
      tperm[rr] <= mem_rsp_data[3:0];
    end
  end

  // R10
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tv == '0));

  // R9
  single_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hitv));

  // R8
  fault_nopa_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault != 2'd0) |-> (rsp_paddr == '0));

  // R3
  memreq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R4
  hit_nomem_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && |hitv) |=> (rsp_valid && !mem_req_valid));
endmodule

// File: tb/page_xlate_tb.sv
module page_xlate_tb;
  logic clk = 0;
  logic rst_n = 0;
  logic flush_tb = 0, flush_m = 0, flush;
  logic pt_base_we = 0;
  logic [31:0] pt_base_d = 0;
  logic req_valid = 0;
  logic req_ready;
  logic [31:0] req_vaddr = 0;
  logic [1:0] req_acc = 0;
  logic rsp_valid;
  logic [31:0] rsp_paddr;
  logic [1:0] rsp_fault;
  logic mem_req_valid;
  logic [31:0] mem_req_addr;
  logic mem_req_ready = 0;
  logic mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;

  int tests = 0, fails = 0, nreads = 0;
  logic [31:0] last_addr = 0;
  logic [31:0] cur_base = 0;
  logic flush_on_fill = 0;
  int wcnt = 0, dcnt = 0;
  logic pend = 0;

  always #5 clk = ~clk;
  assign flush = flush_tb | flush_m;

  page_xlate u_dut (
    .clk(clk), .rst_n(rst_n), .flush(flush), .pt_base_we(pt_base_we), .pt_base_d(pt_base_d),
    .req_valid(req_valid), .req_ready(req_ready), .req_vaddr(req_vaddr), .req_acc(req_acc),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault),
    .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr), .mem_req_ready(mem_req_ready),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  function automatic logic [19:0] frame_of(input logic [19:0] vpn);
    return vpn ^ 20'h84000;
  endfunction

  function automatic logic [31:0] pte_of(input logic [19:0] vpn);
    return {frame_of(vpn), 8'h00, vpn[3:0]};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mem_req_ready <= 0; mem_rsp_valid <= 0; flush_m <= 0; pend <= 0; wcnt <= 0; dcnt <= 0;
    end else begin
      mem_rsp_valid <= 0;
      flush_m <= 0;
      if (mem_req_valid && mem_req_ready) begin
        mem_req_ready <= 0;
        nreads <= nreads + 1;
        last_addr <= mem_req_addr;
        pend <= 1; dcnt <= 2; wcnt <= 0;
      end else if (mem_req_valid) begin
        if (wcnt == 2) mem_req_ready <= 1;
        wcnt <= wcnt + 1;
      end
      if (pend) begin
        if (dcnt == 0) begin
          pend <= 0;
          mem_rsp_valid <= 1;
          mem_rsp_data <= pte_of(20'((last_addr - cur_base) >> 2));
          flush_m <= flush_on_fill;
        end else dcnt <= dcnt - 1;
      end
    end
  end

  task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input logic [31:0] va, input logic [1:0] acc,
                        output logic [31:0] pa, output logic [1:0] f, output int lat, output int rd);
    int r0;
    r0 = nreads;
    @(negedge clk);
    req_vaddr = va; req_acc = acc; req_valid = 1;
    @(negedge clk);
    req_valid = 0;
    lat = 1;
    while (!rsp_valid && lat < 200) begin
      @(negedge clk);
      lat++;
    end
    pa = rsp_paddr; f = rsp_fault; rd = nreads - r0;
  endtask

  task automatic set_base(input logic [31:0] b);
    @(negedge clk);
    pt_base_we = 1; pt_base_d = b; cur_base = b;
    @(negedge clk);
    pt_base_we = 0;
  endtask

  task automatic do_flush();
    @(negedge clk); flush_tb = 1;
    @(negedge clk); flush_tb = 0;
  endtask

  task automatic t_reset();
    check(req_ready == 1, "R1 req_ready", 32'(req_ready), 1);
    check(rsp_valid == 0, "R1 rsp_valid", 32'(rsp_valid), 0);
    check(mem_req_valid == 0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_miss_hit();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    set_base(32'h0010_0000);
    access(32'h0000_FABC, 0, pa, f, lat, rd);
    check(rd == 1, "R1 R3 first access reads table", 32'(rd), 1);
    check(last_addr == 32'h0010_003C, "R3 R12 entry address", last_addr, 32'h0010_003C);
    check(pa == {frame_of(20'hF), 12'hABC}, "R2 miss paddr", pa, {frame_of(20'hF), 12'hABC});
    check(f == 0, "R2 miss fault", 32'(f), 0);
    access(32'h0000_F123, 0, pa, f, lat, rd);
    check(rd == 0, "R5 refill hit no read", 32'(rd), 0);
    check(lat == 1, "R4 hit latency", 32'(lat), 1);
    check(pa == {frame_of(20'hF), 12'h123}, "R4 R2 hit paddr", pa, {frame_of(20'hF), 12'h123});
  endtask

  task automatic t_faults();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    access(32'h0002_0010, 0, pa, f, lat, rd);
    check(f == 1, "R6 invalid fault", 32'(f), 1);
    check(pa == 0, "R8 fault paddr zero", pa, 0);
    access(32'h0002_0FFF, 2, pa, f, lat, rd);
    check(f == 1 && rd == 0, "R6 invalid kept, no read", {f, 30'(rd)}, {2'd1, 30'd0});
    access(32'h0002_3004, 1, pa, f, lat, rd);
    check(f == 2, "R7 write violation", 32'(f), 2);
    check(pa == 0, "R8 write fault paddr", pa, 0);
    access(32'h0002_3008, 2, pa, f, lat, rd);
    check(f == 3, "R7 execute violation", 32'(f), 3);
    access(32'h0002_300C, 0, pa, f, lat, rd);
    check(f == 0 && pa == {frame_of(20'h23), 12'h00C}, "R7 read allowed", pa, {frame_of(20'h23), 12'h00C});
    access(32'h0002_1000, 0, pa, f, lat, rd);
    check(f == 1, "R7 read without read bit", 32'(f), 1);
    access(32'h0002_D000, 0, pa, f, lat, rd);
    check(f == 1, "R7 read denied on write/exec page", 32'(f), 1);
    access(32'h0002_D000, 1, pa, f, lat, rd);
    check(f == 0 && rd == 0, "R7 write allowed hit", 32'(f), 0);
    access(32'h0002_6000, 1, pa, f, lat, rd);
    check(f == 1, "R7 invalid beats write check", 32'(f), 1);
  endtask

  task automatic t_flush();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    access(32'h0000_F000, 0, pa, f, lat, rd);
    check(rd == 0, "R10 precondition hit", 32'(rd), 0);
    do_flush();
    access(32'h0000_F000, 0, pa, f, lat, rd);
    check(rd == 1, "R10 miss after flush", 32'(rd), 1);
  endtask

  task automatic t_base();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    set_base(32'h0020_0000);
    access(32'h0003_F000, 0, pa, f, lat, rd);
    check(last_addr == 32'h0020_00FC, "R12 new base used", last_addr, 32'h0020_00FC);
  endtask

  task automatic t_flush_fill();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    flush_on_fill = 1;
    access(32'h0004_F777, 0, pa, f, lat, rd);
    flush_on_fill = 0;
    check(f == 0 && pa == {frame_of(20'h4F), 12'h777}, "R11 response during flush", pa, {frame_of(20'h4F), 12'h777});
    access(32'h0004_F777, 0, pa, f, lat, rd);
    check(rd == 1, "R11 entry dropped", 32'(rd), 1);
  endtask

  task automatic t_rr();
    logic [31:0] pa; logic [1:0] f; int lat, rd;
    do_flush();
    for (int k = 0; k < 9; k++) begin
      access({12'h001, 4'(k), 4'hF, 12'h000}, 0, pa, f, lat, rd);
      check(rd == 1, "R9 distinct fill misses", 32'(rd), 1);
    end
    access(32'h0011_F000, 0, pa, f, lat, rd);
    check(rd == 0, "R9 second page survives", 32'(rd), 0);
    access(32'h0010_F000, 0, pa, f, lat, rd);
    check(rd == 1, "R9 oldest page evicted", 32'(rd), 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog act=0 exp=1");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_miss_hit();
    t_faults();
    t_flush();
    t_base();
    t_flush_fill();
    t_rr();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule